// File: doc/BRIEF.md
# Master Clock Ratio Detector and Power Sequencer

This block watches the master clock against the sample-rate frame clock. It counts master-clock cycles between rising edges of the frame clock and matches each count against six oversampling ratios: 128, 192, 256, 384, 512 and 768. It reports the matched ratio as a 3-bit code and raises a high-rate flag for the two fastest ratios, which run the converter path at 64x oversampling instead of 128x. Mute stays asserted until the ratio is stable. A count that falls outside every tolerance window forces mute again.

A watchdog runs on a free-running reference clock. It notices when the master clock stops and then forces power-down and mute. The same reference domain synchronises the enable pin and the de-emphasis pin.

The de-emphasis pin has two roles. Its level at the moment enable rises sets a sticky high-performance mode. After that, its live level switches de-emphasis on and off. The frame clock must be synchronous to the master clock. The enable and de-emphasis pins may be fully asynchronous.

Top module: `mcr_top`

## Requirements
- R1: A frame period of N master-clock cycles is classified as code 0 for 128, 1 for 192, 2 for 256, 3 for 384, 4 for 512 and 5 for 768. Code 7 means unlocked, and code 6 never appears.
- R2: A period is in tolerance when it lies within TOL (default 8) cycles of a ratio, bounds included. A period 9 cycles away gives code 7 and mute.
- R3: `high_rate` is 1 exactly when the reported code is 0 or 1, and 0 for every other code, including 7.
- R4: Mute is released, and the code becomes valid, only after two consecutive in-tolerance periods of the same ratio. The first period of a new ratio reports code 7 and mute until a second matching period is seen.
- R5: If the master clock stops for more than STOP_CYCLES reference cycles, `power_down` and `mute` assert. Both clear again shortly after the clock restarts.
- R6: While enable is low, `power_down` is 1, `deemph_on` is 0 and `hiperf` is 0.
- R7: The de-emphasis pin level seen when enable rises is held on `hiperf` for as long as enable stays high. Later changes of the pin do not change it.
- R8: While enable is high, `deemph_on` follows the de-emphasis pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| refclk | input | 1 | Free-running reference clock for the watchdog and pin logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| fclk | input | 1 | Frame (sample-rate) clock, synchronous to mclk |
| enable_pin | input | 1 | Enable pin; low selects the low-power state |
| deemph_pin | input | 1 | Mode sample at enable rise, de-emphasis select afterwards |
| ratio_code | output | 3 | Matched ratio code; 7 means unlocked |
| high_rate | output | 1 | 64x oversampling select (ratio 128 or 192) |
| mute | output | 1 | Output mute |
| power_down | output | 1 | Power-down request |
| hiperf | output | 1 | Latched high-performance mode |
| deemph_on | output | 1 | De-emphasis filter enable |

## Verification
The ratio results are registered on the master-clock edge that first sees the frame clock high. That edge closes the measurement of the previous period. The bench therefore samples `ratio_code`, `high_rate` and `mute` 1 ns after that edge, after exactly three full frames, so that the last two completed periods are the ones under test.

The pin results pass two synchroniser stages and one output register. They are due on the third reference edge after a pin change, and the bench samples just after that edge. Detection of a stopped master clock needs STOP_CYCLES reference cycles plus the synchroniser and output stages. The bench therefore checks it after STOP_CYCLES+10 reference cycles, and checks that it has cleared 20 cycles after the clock restarts.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int NUM_RATIOS = 6;
  typedef logic [2:0] ratio_code_t;
  localparam ratio_code_t CODE_NONE = 3'd7;

  // ratios 128,192,256,384,512,768 from index 0..5
  function automatic int unsigned ratio_value(input int idx);
    return (128 + 64 * (idx % 2)) << (idx / 2);
  endfunction
endpackage

// File: rtl/mcr_ratio_meter.sv
module mcr_ratio_meter
  import mcr_pkg::*;
#(
  parameter int TOL   = 8,
  parameter int CNT_W = 11
) (
  input  logic        mclk,
  input  logic        rst_n,
  input  logic        fclk,
  output ratio_code_t code_o,
  output logic        locked_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             fclk_d, seen, locked_q, rise;
  logic [CNT_W-1:0] cnt;
  ratio_code_t      prev_code, code_q, meas_code;
  logic [NUM_RATIOS-1:0] hit;

  assign rise = fclk & ~fclk_d;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam logic [CNT_W-1:0] LO = CNT_W'(ratio_value(i) - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(ratio_value(i) + TOL);
    assign hit[i] = (cnt >= LO) && (cnt <= HI);
  end

  always_comb begin
    meas_code = CODE_NONE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--)
      if (hit[i]) meas_code = ratio_code_t'(i);
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_d    <= 1'b0;
      cnt       <= '0;
      seen      <= 1'b0;
      prev_code <= CODE_NONE;
      code_q    <= CODE_NONE;
      locked_q  <= 1'b0;
    end else begin
      fclk_d <= fclk;
      if (rise) begin
        cnt  <= CNT_W'(1);
        seen <= 1'b1;
        if (seen) begin
          prev_code <= meas_code;
          if (meas_code != CODE_NONE && meas_code == prev_code) begin
            locked_q <= 1'b1;
            code_q   <= meas_code;
          end else begin
            locked_q <= 1'b0;
            code_q   <= CODE_NONE;
          end
        end
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign code_o   = code_q;
  assign locked_o = locked_q;

  assert_mismatch_mutes_R2: assert property (@(posedge mclk) disable iff (!rst_n)
    (rise && seen && meas_code == CODE_NONE) |=> !locked_q);
  assert_lock_on_edge_R4: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(rise));
  assert_code_held_R4: assert property (@(posedge mclk) disable iff (!rst_n)
    !rise |=> $stable(code_q));
  assert_no_code6_R1: assert property (@(posedge mclk) disable iff (!rst_n)
    code_q != 3'd6);
endmodule

// File: rtl/mcr_clk_watchdog.sv
module mcr_clk_watchdog #(
  parameter int STOP_CYCLES = 150
) (
  input  logic mclk,
  input  logic refclk,
  input  logic rst_n,
  output logic stopped_o
);
  localparam int WD_W = $clog2(STOP_CYCLES + 1);
  localparam logic [WD_W-1:0] LIMIT = WD_W'(STOP_CYCLES);

  logic            tgl, s1, s2, s3, edge_seen, stopped_q;
  logic [WD_W-1:0] wd_cnt;

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;

  assign edge_seen = s2 ^ s3;

  always_ff @(posedge refclk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      wd_cnt    <= '0;
      stopped_q <= 1'b0;
    end else begin
      s1 <= tgl; s2 <= s1; s3 <= s2;
      if (edge_seen)            wd_cnt <= '0;
      else if (wd_cnt != LIMIT) wd_cnt <= wd_cnt + 1'b1;
      stopped_q <= !edge_seen && (wd_cnt == LIMIT);
    end
  end

  assign stopped_o = stopped_q;

  assert_stop_needs_silence_R5: assert property (@(posedge refclk) disable iff (!rst_n)
    $rose(stopped_q) |-> $past(!edge_seen));
  assert_toggle_clears_R5: assert property (@(posedge refclk) disable iff (!rst_n)
    edge_seen |=> !stopped_q);
endmodule

// File: rtl/mcr_power_ctrl.sv
module mcr_power_ctrl (
  input  logic refclk,
  input  logic rst_n,
  input  logic enable_pin,
  input  logic deemph_pin,
  input  logic stopped,
  output logic power_down,
  output logic hiperf,
  output logic deemph_on
);
  logic en_m, en_s, dm_m, dm_s, en_prev;
  logic pd_q, hp_q, de_q;

  always_ff @(posedge refclk or negedge rst_n) begin
    if (!rst_n) begin
      en_m <= 1'b0; en_s <= 1'b0; dm_m <= 1'b0; dm_s <= 1'b0;
      en_prev <= 1'b0;
      pd_q <= 1'b1; hp_q <= 1'b0; de_q <= 1'b0;
    end else begin
      en_m <= enable_pin; en_s <= en_m;
      dm_m <= deemph_pin; dm_s <= dm_m;
      en_prev <= en_s;
      pd_q <= !en_s || stopped;
      de_q <= en_s && dm_s;
      if (!en_s)              hp_q <= 1'b0;
      else if (!en_prev)      hp_q <= dm_s;
    end
  end

  assign power_down = pd_q;
  assign hiperf     = hp_q;
  assign deemph_on  = de_q;

  assert_disabled_powers_down_R6: assert property (@(posedge refclk) disable iff (!rst_n)
    !en_s |=> (pd_q && !hp_q && !de_q));
  assert_mode_sticky_R7: assert property (@(posedge refclk) disable iff (!rst_n)
    (en_s && en_prev) |=> $stable(hp_q));
  assert_deemph_follows_R8: assert property (@(posedge refclk) disable iff (!rst_n)
    (en_s && dm_s) |=> de_q);
endmodule

// File: rtl/mcr_top.sv
module mcr_top #(
  parameter int TOL         = 8,
  parameter int CNT_W       = 11,
  parameter int STOP_CYCLES = 150
) (
  input  logic       mclk,
  input  logic       refclk,
  input  logic       rst_n,
  input  logic       fclk,
  input  logic       enable_pin,
  input  logic       deemph_pin,
  output logic [2:0] ratio_code,
  output logic       high_rate,
  output logic       mute,
  output logic       power_down,
  output logic       hiperf,
  output logic       deemph_on
);
  import mcr_pkg::*;

  ratio_code_t code;
  logic        locked, stopped, pd;

  mcr_ratio_meter #(.TOL(TOL), .CNT_W(CNT_W)) u_meter (
    .mclk(mclk), .rst_n(rst_n), .fclk(fclk),
    .code_o(code), .locked_o(locked));

  mcr_clk_watchdog #(.STOP_CYCLES(STOP_CYCLES)) u_wd (
    .mclk(mclk), .refclk(refclk), .rst_n(rst_n), .stopped_o(stopped));

  mcr_power_ctrl u_pwr (
    .refclk(refclk), .rst_n(rst_n), .enable_pin(enable_pin),
    .deemph_pin(deemph_pin), .stopped(stopped),
    .power_down(pd), .hiperf(hiperf), .deemph_on(deemph_on));

  assign ratio_code = code;
  assign high_rate  = locked && (code == 3'd0 || code == 3'd1);
  assign mute       = !locked || pd;
  assign power_down = pd;
endmodule

// File: tb/mcr_top_test.sv
module mcr_top_test;
  logic mclk = 1'b0, refclk = 1'b0, rst_n = 1'b0;
  logic fclk = 1'b0, enable_pin = 1'b0, deemph_pin = 1'b0;
  logic mclk_run = 1'b1;
  logic [2:0] ratio_code;
  logic high_rate, mute, power_down, hiperf, deemph_on;
  int total = 0, bad = 0;
  bit done = 0;
  localparam int STOP = 150;

  mcr_top uut (.mclk(mclk), .refclk(refclk), .rst_n(rst_n), .fclk(fclk),
    .enable_pin(enable_pin), .deemph_pin(deemph_pin), .ratio_code(ratio_code),
    .high_rate(high_rate), .mute(mute), .power_down(power_down),
    .hiperf(hiperf), .deemph_on(deemph_on));

  always begin #5; if (mclk_run) mclk = ~mclk; end
  always #6 refclk = ~refclk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_ratio(input string tag, input int exp_code);
    chk({tag, " code"}, ratio_code, exp_code);
    chk("R3 high_rate", high_rate, (exp_code <= 1) ? 1 : 0);
    chk({tag, " mute"}, mute, (exp_code == 7) ? 1 : 0);
  endtask

  // one frame of p mclk cycles; optional check at its opening edge
  task automatic frame(input int p, input bit do_chk, input string tag, input int exp_code);
    int h = p / 2;
    fclk = 1'b1;
    if (do_chk) begin
      @(posedge mclk); #1; check_ratio(tag, exp_code);
      @(negedge mclk);
      repeat (h - 1) @(negedge mclk);
    end else repeat (h) @(negedge mclk);
    fclk = 1'b0;
    repeat (p - h) @(negedge mclk);
  endtask

  task automatic pins(input logic en, input logic dm);
    @(negedge refclk); enable_pin = en; deemph_pin = dm;
    repeat (3) @(posedge refclk); #1;
  endtask

  function automatic int expect_code(input int p);
    for (int i = 0; i < 6; i++) begin
      int r = (128 + 64 * (i % 2)) << (i / 2);
      if (p >= r - 8 && p <= r + 8) return i;
    end
    return 7;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge refclk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset code", ratio_code, 7);
    chk("R4 reset mute", mute, 1);
    chk("R6 reset power_down", power_down, 1);
    // power sequencing
    pins(1'b0, 1'b1);
    chk("R6 en low pd", power_down, 1);
    chk("R6 en low deemph", deemph_on, 0);
    chk("R6 en low hiperf", hiperf, 0);
    pins(1'b1, 1'b1);
    chk("R7 latch hiperf", hiperf, 1);
    chk("R8 deemph on", deemph_on, 1);
    chk("R6 powered up", power_down, 0);
    pins(1'b1, 1'b0);
    chk("R7 hiperf sticky", hiperf, 1);
    chk("R8 deemph off", deemph_on, 0);
    pins(1'b0, 1'b0);
    chk("R6 drop clears hiperf", hiperf, 0);
    chk("R6 drop pd", power_down, 1);
    pins(1'b1, 1'b0);
    chk("R7 normal mode", hiperf, 0);
    pins(1'b1, 1'b1);
    chk("R7 pin ignored after rise", hiperf, 0);
    chk("R8 deemph follows", deemph_on, 1);
    // ratio sweep
    @(negedge mclk);
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < 5; k++) begin
        int offs[5] = '{-9, -8, 0, 8, 9};
        int r = (128 + 64 * (i % 2)) << (i / 2);
        int p = r + offs[k];
        int e = expect_code(p);
        repeat (3) frame(p, 1'b0, "", 0);
        frame(p, 1'b1, (e == 7) ? "R2" : "R1", e);
      end
    end
    // ratio change: 256 locked then 512
    repeat (3) frame(256, 1'b0, "", 0);
    frame(256, 1'b1, "R4 locked 256", 2);
    frame(512, 1'b1, "R4 first of new ratio", 2);
    frame(512, 1'b1, "R4 one new period", 7);
    frame(512, 1'b1, "R4 relock 512", 4);
    // stopped master clock
    repeat (3) frame(384, 1'b0, "", 0);
    chk("R5 running pd", power_down, 0);
    @(negedge mclk); @(posedge mclk); #1; mclk_run = 1'b0;
    repeat (STOP + 10) @(posedge refclk); #1;
    chk("R5 stopped pd", power_down, 1);
    chk("R5 stopped mute", mute, 1);
    mclk_run = 1'b1;
    repeat (20) @(posedge refclk); #1;
    chk("R5 restart pd", power_down, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule